// File: doc/BRIEF.md
# Serial Receiver Error Flag Unit

This unit keeps the error and status flags for the receive side of an asynchronous serial port. The receiver core pulses `ev_done` once per finished character. With that pulse it reports what it saw: noise during sampling, a parity mismatch, the sampled stop-bit value, and whether every data and parity bit was 0. The unit turns these reports into sticky flags and exposes them in two status bytes. It also drives one error interrupt line, gated by three enable bits.

Software clears a flag in two steps. It first reads the status byte that holds the flag while the flag is set, and then reads the data register. A data read on its own clears nothing.

A character in which all data bits, the parity bit and the stop bit are 0 is a break. A break sets the break flag, the framing flag and the receive-full flag together, and forces the stored ninth data bit to 0. After the break flag has been cleared, it can set again only once the line has been seen high.

Top module: `rx_err_flags`

## Requirements
- R1: `ev_done` together with `ev_noise` sets the noise flag, which is bit 2 of `stat1`, on the next clock.
- R2: `ev_done` with `stop_bit` = 0 sets the framing flag, bit 1 of `stat1`. Every `ev_done` sets the receive-full flag, bit 5 of `stat1`.
- R3: `ev_done` together with `ev_parity` sets the parity flag, bit 0 of `stat1`.
- R4: A flag in `stat1` clears only when `rd_stat1` is pulsed while the flag is set and `rd_data` is pulsed in a later cycle. A `rd_data` pulse without that earlier status read leaves every flag unchanged.
- R5: A break is `ev_done` with `stop_bit` = 0, `data_zero` = 1, and the unit armed. It sets the break flag (bit 1 of `stat2`), the framing flag and the full flag in the same cycle.
- R6: On each `ev_done`, `rx9` loads `rx_bit9` when `mode_9bit` = 1 and loads 0 otherwise. A break loads 0 in either mode.
- R7: The break flag clears only after `rd_stat2` is pulsed while the flag is set, followed later by `rd_data`. The `stat1` read sequence does not clear it.
- R8: A detected break disarms detection. The unit re-arms only when `line_in` is 1 while the break flag is clear. An all-zero character that arrives while the unit is disarmed sets the framing and full flags but not the break flag.
- R9: `err_irq` is (noise AND `en_noise`) OR (framing AND `en_frame`) OR (parity AND `en_parity`). The break flag never raises it.
- R10: Reset clears every flag, `rx9` and `err_irq`, and arms break detection. All bits of `stat2` other than bit 1 always read 0.
- R11: If a set event arrives in the same cycle as the clearing `rd_data`, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_done | input | 1 | Character-complete strobe |
| ev_noise | input | 1 | Noise seen in this character (qualified by ev_done) |
| ev_parity | input | 1 | Parity mismatch in this character (qualified by ev_done) |
| stop_bit | input | 1 | Sampled stop-bit value |
| data_zero | input | 1 | All data and parity bits were 0 |
| rx_bit9 | input | 1 | Received ninth data bit |
| mode_9bit | input | 1 | 9-bit character mode |
| line_in | input | 1 | Raw receive line level |
| rd_stat1 | input | 1 | CPU read strobe of status byte 1 |
| rd_stat2 | input | 1 | CPU read strobe of status byte 2 |
| rd_data | input | 1 | CPU read strobe of the data register |
| en_noise | input | 1 | Noise interrupt enable |
| en_frame | input | 1 | Framing interrupt enable |
| en_parity | input | 1 | Parity interrupt enable |
| stat1 | output | STAT_W | Status byte 1: parity bit 0, framing bit 1, noise bit 2, full bit 5 |
| stat2 | output | STAT_W | Status byte 2: break bit 1, all other bits 0 |
| rx9 | output | 1 | Stored ninth data bit |
| err_irq | output | 1 | Combined error interrupt request |

## Verification
The assertions assume that the error strobes and `stop_bit`/`data_zero` carry meaning only in a cycle where `ev_done` is high, and that each read strobe lasts a single cycle. The stimulus keeps to this. Every character and every read is a one-cycle pulse driven at the falling edge, and the strobes return to 0 in the next cycle. `line_in` is held high except around the break cases, where it is held low on purpose so that re-arming can be checked.

// File: rtl/rx_err_flags.sv
module rx_err_flags #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_done,
  input  logic              ev_noise,
  input  logic              ev_parity,
  input  logic              stop_bit,
  input  logic              data_zero,
  input  logic              rx_bit9,
  input  logic              mode_9bit,
  input  logic              line_in,
  input  logic              rd_stat1,
  input  logic              rd_stat2,
  input  logic              rd_data,
  input  logic              en_noise,
  input  logic              en_frame,
  input  logic              en_parity,
  output logic [STAT_W-1:0] stat1,
  output logic [STAT_W-1:0] stat2,
  output logic              rx9,
  output logic              err_irq
);
  localparam int B_PAR  = 0;
  localparam int B_FRM  = 1;
  localparam int B_NSE  = 2;
  localparam int B_FULL = 5;
  localparam int B_BRK  = 1;
  localparam int NFLG   = 4;

  // flag vector: [0] parity, [1] framing, [2] noise, [3] full
  logic [NFLG-1:0] flg_q, pend_q, set_v;
  logic brk_q, brk_pend_q, armed_q, rx9_q, brk_det;

  assign brk_det = ev_done & ~stop_bit & data_zero & armed_q;
  assign set_v   = {ev_done, ev_done & ev_noise, ev_done & ~stop_bit, ev_done & ev_parity};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_q      <= '0;
      pend_q     <= '0;
      brk_q      <= 1'b0;
      brk_pend_q <= 1'b0;
      armed_q    <= 1'b1;
      rx9_q      <= 1'b0;
    end else begin
      flg_q      <= (flg_q & ~({NFLG{rd_data}} & pend_q)) | set_v;
      pend_q     <= rd_data ? '0 : (pend_q | ({NFLG{rd_stat1}} & flg_q));
      brk_q      <= (brk_q & ~(rd_data & brk_pend_q)) | brk_det;
      brk_pend_q <= rd_data ? 1'b0 : (brk_pend_q | (rd_stat2 & brk_q));
      if (brk_det)
        armed_q <= 1'b0;
      else if (line_in && !brk_q)
        armed_q <= 1'b1;
      if (ev_done)
        rx9_q <= mode_9bit & rx_bit9 & ~brk_det;
    end
  end

  always_comb begin
    stat1         = '0;
    stat1[B_PAR]  = flg_q[0];
    stat1[B_FRM]  = flg_q[1];
    stat1[B_NSE]  = flg_q[2];
    stat1[B_FULL] = flg_q[3];
    stat2         = '0;
    stat2[B_BRK]  = brk_q;
  end

  assign rx9     = rx9_q;
  assign err_irq = (flg_q[2] & en_noise) | (flg_q[1] & en_frame) | (flg_q[0] & en_parity);
endmodule

// File: rtl/rx_err_flags_chk.sv
module rx_err_flags_chk #(
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_done,
  input logic              ev_noise,
  input logic              ev_parity,
  input logic              stop_bit,
  input logic              brk_det,
  input logic              rd_data,
  input logic [STAT_W-1:0] stat1,
  input logic [STAT_W-1:0] stat2,
  input logic              rx9,
  input logic              err_irq
);
  assert_noise_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done && ev_noise |=> stat1[2]);
  assert_frame_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done && !stop_bit |=> stat1[1] && stat1[5]);
  assert_parity_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done && ev_parity |=> stat1[0]);
  assert_clear_by_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat1[2]) || $fell(stat1[1]) || $fell(stat1[0]) |-> $past(rd_data));
  assert_break_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |=> stat2[1] && stat1[1] && stat1[5] && !rx9);
  assert_break_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat2[1]) |-> $past(rd_data));
  assert_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat1[2:0] == 3'b000 |-> !err_irq);
endmodule

bind rx_err_flags rx_err_flags_chk #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_noise(ev_noise),
  .ev_parity(ev_parity), .stop_bit(stop_bit), .brk_det(brk_det),
  .rd_data(rd_data), .stat1(stat1), .stat2(stat2), .rx9(rx9), .err_irq(err_irq)
);

// File: tb/rx_err_flags_tb.sv
`timescale 1ns/1ps
module rx_err_flags_tb;
  logic clk = 0, rst_n = 0;
  logic ev_done = 0, ev_noise = 0, ev_parity = 0, stop_bit = 1, data_zero = 0;
  logic rx_bit9 = 0, mode_9bit = 0, line_in = 1;
  logic rd_stat1 = 0, rd_stat2 = 0, rd_data = 0;
  logic en_noise = 0, en_frame = 0, en_parity = 0;
  logic [7:0] stat1, stat2;
  logic rx9, err_irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  rx_err_flags u_dut (.*);

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic char(input logic n, p, s, z, b9);
    @(negedge clk);
    ev_done = 1; ev_noise = n; ev_parity = p; stop_bit = s; data_zero = z; rx_bit9 = b9;
    @(negedge clk);
    ev_done = 0; ev_noise = 0; ev_parity = 0; stop_bit = 1; data_zero = 0; rx_bit9 = 0;
  endtask

  task automatic rd(input logic s1, s2, d);
    @(negedge clk);
    rd_stat1 = s1; rd_stat2 = s2; rd_data = d;
    @(negedge clk);
    rd_stat1 = 0; rd_stat2 = 0; rd_data = 0;
  endtask

  task automatic clear_all();
    rd(1, 0, 0); rd(0, 1, 0); rd(0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset stat1", stat1, 0);
    check("R10 reset stat2", stat2, 0);
    check("R10 reset rx9", rx9, 0);
    check("R10 reset irq", err_irq, 0);

    for (int i = 0; i < 8; i++) begin
      int exp;
      clear_all();
      char(i[0], i[1], ~i[2], 0, 0);
      exp = 32 | (i[0] << 2) | (i[2] << 1) | i[1];
      check("R1 R2 R3 set pattern", stat1, exp);
      check("R10 stat2 idle", stat2, 0);
      for (int e = 0; e < 8; e++) begin
        @(negedge clk);
        en_noise = e[0]; en_frame = e[1]; en_parity = e[2];
        #1;
        check("R9 irq", err_irq, (i[0] & e[0]) | (i[2] & e[1]) | (i[1] & e[2]));
      end
      en_noise = 0; en_frame = 0; en_parity = 0;
      rd(0, 0, 1);
      check("R4 data read alone keeps flags", stat1, exp);
      rd(1, 0, 0);
      rd(0, 0, 1);
      check("R4 sequence clears", stat1, 0);
    end

    mode_9bit = 1;
    char(0, 0, 1, 0, 1);
    check("R6 ninth bit in 9-bit mode", rx9, 1);
    mode_9bit = 0;
    char(0, 0, 1, 0, 1);
    check("R6 ninth bit in 8-bit mode", rx9, 0);
    clear_all();

    mode_9bit = 1;
    line_in = 0;
    char(0, 0, 0, 1, 1);
    check("R5 break flag", stat2, 2);
    check("R5 frame and full", stat1, 8'h22);
    check("R6 break forces rx9", rx9, 0);
    check("R9 break alone no irq", err_irq, 0);
    rd(1, 0, 0); rd(0, 0, 1);
    check("R7 stat1 sequence clears stat1", stat1, 0);
    check("R7 stat1 sequence keeps break", stat2, 2);
    rd(0, 1, 0); rd(0, 0, 1);
    check("R7 stat2 sequence clears break", stat2, 0);
    char(0, 0, 0, 1, 0);
    check("R8 no break while disarmed", stat2, 0);
    check("R8 disarmed framing", stat1, 8'h22);
    clear_all();
    @(negedge clk); line_in = 1;
    @(negedge clk); line_in = 0;
    char(0, 0, 0, 1, 0);
    check("R8 break after line high", stat2, 2);
    clear_all();
    check("R8 break cleared", stat2, 0);
    line_in = 1;
    mode_9bit = 0;

    char(1, 0, 1, 0, 0);
    rd(1, 0, 0);
    @(negedge clk);
    rd_data = 1; ev_done = 1; ev_noise = 1;
    @(negedge clk);
    rd_data = 0; ev_done = 0; ev_noise = 0;
    check("R11 set wins over clear", stat1, 8'h24);
    rd(1, 0, 0); rd(0, 0, 1);
    check("R11 later sequence clears", stat1, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule